// File: doc/BRIEF.md
# Masked Input Change Detector

This block watches a small group of asynchronous input pins and records when they change. Each pin first crosses into the local clock domain through a short flop chain. The synchronized level is then compared with its value one cycle earlier. A per-pin setting picks what counts as a change. In one mode either direction counts. In the other mode only one direction counts, and a polarity bit chooses which one. A qualifying change sets a sticky flag for that pin.

Software sees a single status word. The upper half holds the sticky flags and the lower half holds the live synchronized levels. A read of that word, signalled by a one-cycle strobe, clears the flags. If a new qualifying change lands in the same cycle as the read, that flag stays set, so the change is not lost. Each pin also has an enable bit. The interrupt output is asserted while any enabled pin has its flag set. Configuration arrives on plain input ports that an enclosing register file drives.

Top module: `edge_watch`

## Requirements
- R1: After reset, status_o reads all zeros and irq_o is low.
- R2: A pin level reaches status_o[N_IN-1:0] after SYNC_STAGES clock edges. With the default of 2, a pin changed before edge k shows up after edge k+1.
- R3: When cfg_both_i[b] is 1, any change of the synchronized level of pin b sets flag b (status_o[N_IN+b]). The flag appears one edge after the new level appears in status_o.
- R4: When cfg_both_i[b] is 0 and cfg_rise_i[b] is 1, only a 0-to-1 change sets flag b. A 1-to-0 change leaves it clear.
- R5: When cfg_both_i[b] is 0 and cfg_rise_i[b] is 0, only a 1-to-0 change sets flag b. A 0-to-1 change leaves it clear.
- R6: A set flag stays set, without further changes, until a read clears it.
- R7: status_o shows the flags during the read cycle. Every flag is cleared by the edge at which flags_rd_i is high, and irq_o then falls.
- R8: A qualifying change detected in the same cycle as a read leaves its flag set after that edge.
- R9: irq_o is high exactly when some pin b has flag b set and cfg_en_i[b] = 1. Flags of disabled pins still latch and stay visible in status_o.
- R10: A change on one pin never sets another pin's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_IN | Asynchronous pins being watched |
| cfg_both_i | input | N_IN | Per pin: 1 = both directions count |
| cfg_rise_i | input | N_IN | Per pin, single-direction mode: 1 = rising, 0 = falling |
| cfg_en_i | input | N_IN | Per pin interrupt enable |
| flags_rd_i | input | 1 | Status read strobe; clears the flags at this edge |
| status_o | output | 2*N_IN | {sticky flags, synchronized levels} |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with four pins and a two-stage synchronizer. With only four pins, every combination of mode, polarity and enable across the pins is reachable in the random phase. The short chain means a read can be aimed at the exact cycle in which a change is detected. Directed sequences place the clearing read on that cycle, and the random phase mixes reads with changes on every pin.

// File: rtl/edge_watch_pkg.sv
package edge_watch_pkg;

  // Decide whether a transition from prv to cur counts for one pin.
  function automatic logic edge_counts(logic both, logic rise_sel, logic cur, logic prv);
    logic moved;
    moved = cur ^ prv;
    if (!moved) return 1'b0;
    if (both) return 1'b1;
    return rise_sel ? cur : prv;
  endfunction

  // Next value of a sticky flag given a clear request and a new hit.
  function automatic logic flag_next(logic flag, logic clr, logic hit);
    return (flag & ~clr) | hit;
  endfunction

endpackage

// File: rtl/ew_sync.sv
module ew_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      assert_sync_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stg[g] == $past(stg[g-1]));
    end
  endgenerate

endmodule

// File: rtl/ew_edge_cell.sv
module ew_edge_cell
  import edge_watch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic both,
  input  logic rise_sel,
  input  logic clr,
  output logic hit,
  output logic flag
);
  logic prv;

  assign hit = edge_counts(both, rise_sel, lvl, prv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv  <= 1'b0;
      flag <= 1'b0;
    end else begin
      prv  <= lvl;
      flag <= flag_next(flag, clr, hit);
    end
  end

  assert_hit_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lvl != prv));
  assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!both && rise_sel && !lvl) |-> !hit);
  assert_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!both && !rise_sel && lvl) |-> !hit);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  assert_no_stray_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hit) |=> !flag);

endmodule

// File: rtl/edge_watch.sv
module edge_watch #(
  parameter int N_IN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pin_i,
  input  logic [N_IN-1:0]   cfg_both_i,
  input  logic [N_IN-1:0]   cfg_rise_i,
  input  logic [N_IN-1:0]   cfg_en_i,
  input  logic              flags_rd_i,
  output logic [2*N_IN-1:0] status_o,
  output logic              irq_o
);
  localparam int SW = 2 * N_IN;

  logic [N_IN-1:0] lvl;
  logic [N_IN-1:0] hits;
  logic [N_IN-1:0] flags;

  ew_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(lvl)
  );

  generate
    for (genvar b = 0; b < N_IN; b++) begin : g_cell
      ew_edge_cell u_cell (
        .clk(clk), .rst_n(rst_n), .lvl(lvl[b]), .both(cfg_both_i[b]),
        .rise_sel(cfg_rise_i[b]), .clr(flags_rd_i), .hit(hits[b]), .flag(flags[b])
      );
    end
  endgenerate

  assign status_o = {flags, lvl};
  assign irq_o    = |(flags & cfg_en_i);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[SW-1:N_IN] != '0));
  assert_read_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd_i && hits == '0) |=> !irq_o);

endmodule

// File: tb/test_edge_watch.sv
`timescale 1ns/1ps
module test_edge_watch;
  localparam int N   = 4;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin = '0, both = '1, rise = '0, en = '1;
  logic rd = 1'b0;
  logic [2*N-1:0] status;
  logic irq;

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  edge_watch #(.N_IN(N), .SYNC_STAGES(STG)) i_edge_watch (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_both_i(both), .cfg_rise_i(rise),
    .cfg_en_i(en), .flags_rd_i(rd), .status_o(status), .irq_o(irq)
  );

  // Behavioural reference: a delay queue for the synchronizer, then the rules.
  logic [N-1:0] m_q [$];
  logic [N-1:0] m_lvl, m_seen, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = {};
      for (int i = 0; i < STG - 1; i++) m_q.push_back('0);
      m_lvl = '0; m_seen = '0; m_flag = '0;
    end else begin
      for (int b = 0; b < N; b++) begin
        bit counts;
        counts = (m_lvl[b] != m_seen[b]) && (both[b] || (rise[b] == m_lvl[b]));
        if (rd) m_flag[b] = 1'b0;
        if (counts) m_flag[b] = 1'b1;
      end
      m_seen = m_lvl;
      m_lvl = m_q.pop_front();
      m_q.push_back(pin);
    end
  end

  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      checks++;
      if (status !== {m_flag, m_lvl} || irq !== ((m_flag & en) != '0)) begin
        errors++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", phase,
                 status, irq, {m_flag, m_lvl}, (m_flag & en) != '0);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 0);
    cmp_on = 1'b1;

    phase = "R2";
    pin = 4'b0001;
    tick(); chk("R2 level not yet", status, 8'h00);
    tick(); chk("R2 level arrives", status, 8'h01);
    phase = "R3";
    tick(); chk("R3 flag set", status, 8'h11);
    chk("R3 irq", irq, 1);

    phase = "R7";
    rd = 1'b1;
    chk("R7 flags visible in read cycle", status, 8'h11);
    tick(); rd = 1'b0;
    chk("R7 cleared", status, 8'h01);
    chk("R7 irq low", irq, 0);

    phase = "R4";
    both = 4'b1101; rise = 4'b0010;
    pin = 4'b0011; tick(3);
    chk("R4 rising counts", status, 8'h23);
    do_read();
    pin = 4'b0001; tick(3);
    chk("R4 falling ignored", status, 8'h01);

    phase = "R5";
    both = 4'b1001; rise = 4'b0000;
    pin = 4'b0101; tick(3);
    chk("R5 rising ignored", status, 8'h05);
    pin = 4'b0001; tick(3);
    chk("R5 falling counts", status, 8'h41);
    chk("R10 other flags clear", status[7:4], 4'b0100);

    phase = "R6";
    tick(10);
    chk("R6 flag sticky", status, 8'h41);

    phase = "R8";
    pin = 4'b1001;
    tick(2);
    rd = 1'b1; tick(); rd = 1'b0;
    chk("R8 coinciding change kept", status, 8'h89);

    phase = "R9";
    en = 4'b0111; tick();
    chk("R9 masked irq", irq, 0);
    chk("R9 flag still visible", status, 8'h89);
    en = 4'b1000; tick();
    chk("R9 enabled irq", irq, 1);

    phase = "R3 R4 R5 R7 R9 random";
    for (int i = 0; i < 2000; i++) begin
      pin = $urandom();
      rd = ($urandom() % 4) == 0;
      if ((i % 50) == 0) begin
        both = $urandom(); rise = $urandom(); en = $urandom();
      end
      tick();
    end
    rd = 1'b0;
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule